// File: doc/BRIEF.md
# Banked Multi-Port Register File

This block is a register file with two write ports and five read ports. It holds 36 words of 32 bits, split into a main bank of 32 entries and an auxiliary bank of 4 entries. One shared select line decides the bank for every write port, and a second shared select line decides the bank for every read port. A global inhibit line suppresses all writes at once.

The block runs on a single clock. Separate read and write strobes mark read phases and write phases, and the two phases never coincide. A write lands in storage on the clock edge where the write strobe is high. Each read port captures its result into an output register on the clock edge where the read strobe is high, and keeps that value until the next read phase.

A read port that is not enabled, or that asks for an auxiliary entry with the reserved address bit 2 set, returns all ones. Reset clears every stored word to zero and sets every read output to all ones.

Top module: `banked_regfile`

## Requirements
- R1: While reset is high, and after reset until the first read phase, every read output is all ones. After reset every stored word in both banks reads back as zero.
- R2: When the write strobe is high, inhibit is low, the write bank select is 0 and a port's write enable is 1, that port's data is stored in the main entry given by its full 5-bit address.
- R3: When the write bank select is 1 under the same conditions, the data is stored in the auxiliary entry given by address bits [1:0], and no main entry changes.
- R4: When the inhibit input is high, no entry in either bank changes, whatever the enables and strobe are.
- R5: A write port whose enable is 0 changes no entry during a write phase.
- R6: Both write ports can store to two different addresses in the same write phase, and both words are kept.
- R7: On a clock edge where the read strobe is high, the read bank select is 0 and a port's read enable is 1, that port's output takes the main entry given by its 5-bit address. The value is visible after that edge.
- R8: With the read bank select at 1, an enabled port whose address bit 2 is 0 takes the auxiliary entry given by address bits [1:0].
- R9: With the read bank select at 1, an enabled port whose address bit 2 is 1 outputs all ones.
- R10: A port whose read enable is 0 during a read phase outputs all ones.
- R11: On an edge where the read strobe is low, every read output keeps its value.
- R12: When the write strobe is low, no entry changes, even with enables set.
- R13: The environment rules are flagged when broken. These rules are: the two strobes are never high together; two enabled write ports never use the same address in one write phase; and an auxiliary write never has address bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Write phase marker |
| rd_strobe | input | 1 | Read phase marker |
| wr_inhibit | input | 1 | Blocks every write when high |
| wr_aux_sel | input | 1 | Bank for writes: 0 main, 1 auxiliary |
| rd_aux_sel | input | 1 | Bank for reads: 0 main, 1 auxiliary |
| wr_en | input | 2 | Per-port write enable |
| wr_addr | input | 2x5 | Per-port write address |
| wr_data | input | 2x32 | Per-port write data |
| rd_en | input | 5 | Per-port read enable |
| rd_addr | input | 5x5 | Per-port read address |
| rd_data | output | 5x32 | Per-port registered read data |

## Verification
Both write ports can store in the same write phase. The bench provokes this with a single strobe that carries two enabled ports aimed at different main addresses. It then judges the result by reading both addresses back through several read ports in one read phase, and expects each port to return its own word. Five ports reading the same word together, with others disabled or pointed at the reserved auxiliary range, also exercises the per-port fallback to all ones side by side with normal data in the same phase.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int MAIN_N  = 32;
    localparam int AUX_N   = 4;
    localparam int AUX_IW  = $clog2(AUX_N);
    localparam int RSV_BIT = 2;
    localparam int N_WR    = 2;
    localparam int N_RD    = 5;

    typedef struct packed {
        logic              main_we;
        logic              aux_we;
        logic [ADDR_W-1:0] idx;
    } wsel_t;

    function automatic logic aux_addr_ok(input logic [ADDR_W-1:0] a);
        return !a[RSV_BIT];
    endfunction
endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
module rf_wr_decode
    import rf_pkg::*;
#(
    parameter int NW = N_WR
) (
    input  logic                         strobe,
    input  logic                         inhibit,
    input  logic                         aux_sel,
    input  logic [NW-1:0]                en,
    input  logic [NW-1:0][ADDR_W-1:0]    addr,
    output wsel_t [NW-1:0]               sel
);
    for (genvar p = 0; p < NW; p++) begin : g_port
        logic live;
        assign live           = strobe & ~inhibit & en[p];
        assign sel[p].main_we = live & ~aux_sel;
        assign sel[p].aux_we  = live & aux_sel;
        assign sel[p].idx     = addr[p];
    end
endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage
    import rf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int MN = MAIN_N,
    parameter int AN = AUX_N,
    parameter int NW = N_WR
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wsel_t [NW-1:0]           sel,
    input  logic [NW-1:0][DW-1:0]    wdata,
    output logic [MN-1:0][DW-1:0]    main_q,
    output logic [AN-1:0][DW-1:0]    aux_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= '0;
            aux_q  <= '0;
        end else begin
            for (int p = 0; p < NW; p++) begin
                if (sel[p].main_we)
                    main_q[sel[p].idx] <= wdata[p];
                if (sel[p].aux_we)
                    aux_q[sel[p].idx[AUX_IW-1:0]] <= wdata[p];
            end
        end
    end
endmodule

// File: rtl/rf_rd_port.sv
`timescale 1ns/1ps
module rf_rd_port
    import rf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int MN = MAIN_N,
    parameter int AN = AUX_N
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     strobe,
    input  logic                     aux_sel,
    input  logic                     en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [MN-1:0][DW-1:0]    main_q,
    input  logic [AN-1:0][DW-1:0]    aux_q,
    output logic [DW-1:0]            dout
);
    logic [DW-1:0] nxt;

    always_comb begin
        if (!en)
            nxt = '1;
        else if (aux_sel)
            nxt = aux_addr_ok(addr) ? aux_q[addr[AUX_IW-1:0]] : '1;
        else
            nxt = main_q[addr];
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '1;
        else if (strobe)
            dout <= nxt;
    end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int MN = MAIN_N,
    parameter int AN = AUX_N,
    parameter int NW = N_WR,
    parameter int NR = N_RD
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_strobe,
    input  logic                         rd_strobe,
    input  logic                         wr_inhibit,
    input  logic                         wr_aux_sel,
    input  logic                         rd_aux_sel,
    input  logic [NW-1:0]                wr_en,
    input  logic [NW-1:0][ADDR_W-1:0]    wr_addr,
    input  logic [NW-1:0][DW-1:0]        wr_data,
    input  logic [NR-1:0]                rd_en,
    input  logic [NR-1:0][ADDR_W-1:0]    rd_addr,
    output logic [NR-1:0][DW-1:0]        rd_data
);
    wsel_t [NW-1:0]            sel;
    logic  [MN-1:0][DW-1:0]    main_q;
    logic  [AN-1:0][DW-1:0]    aux_q;

    rf_wr_decode #(.NW(NW)) u_dec (
        .strobe (wr_strobe),
        .inhibit(wr_inhibit),
        .aux_sel(wr_aux_sel),
        .en     (wr_en),
        .addr   (wr_addr),
        .sel    (sel)
    );

    rf_storage #(.DW(DW), .MN(MN), .AN(AN), .NW(NW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .wdata (wr_data),
        .main_q(main_q),
        .aux_q (aux_q)
    );

    for (genvar r = 0; r < NR; r++) begin : g_rd
        rf_rd_port #(.DW(DW), .MN(MN), .AN(AN)) u_port (
            .clk    (clk),
            .rst    (rst),
            .strobe (rd_strobe),
            .aux_sel(rd_aux_sel),
            .en     (rd_en[r]),
            .addr   (rd_addr[r]),
            .main_q (main_q),
            .aux_q  (aux_q),
            .dout   (rd_data[r])
        );
    end
endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
module banked_regfile_chk
    import rf_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NW = N_WR,
    parameter int NR = N_RD
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_strobe,
    input logic                         rd_strobe,
    input logic                         wr_inhibit,
    input logic                         wr_aux_sel,
    input logic                         rd_aux_sel,
    input logic [NW-1:0]                wr_en,
    input logic [NW-1:0][ADDR_W-1:0]    wr_addr,
    input logic [NR-1:0]                rd_en,
    input logic [NR-1:0][ADDR_W-1:0]    rd_addr,
    input logic [NR-1:0][DW-1:0]        rd_data
);
    p_phase_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(wr_strobe && rd_strobe));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data));

    for (genvar i = 0; i < NW; i++) begin : g_wa
        p_aux_rsv_r13: assert property (@(posedge clk) disable iff (rst)
            (wr_strobe && !wr_inhibit && wr_aux_sel && wr_en[i]) |-> !wr_addr[i][RSV_BIT]);
        for (genvar j = i + 1; j < NW; j++) begin : g_wb
            p_addr_clash_r13: assert property (@(posedge clk) disable iff (rst)
                (wr_strobe && !wr_inhibit && wr_en[i] && wr_en[j]) |-> (wr_addr[i] != wr_addr[j]));
        end
    end

    for (genvar r = 0; r < NR; r++) begin : g_rp
        p_rsv_ones_r9: assert property (@(posedge clk) disable iff (rst)
            (rd_strobe && rd_aux_sel && rd_en[r] && rd_addr[r][RSV_BIT]) |=> (rd_data[r] == '1));
        p_idle_ones_r10: assert property (@(posedge clk) disable iff (rst)
            (rd_strobe && !rd_en[r]) |=> (rd_data[r] == '1));
    end
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW), .NW(NW), .NR(NR)) u_chk (.*);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
    logic                  clk = 1'b0;
    logic                  rst;
    logic                  wr_strobe, rd_strobe, wr_inhibit, wr_aux_sel, rd_aux_sel;
    logic [1:0]            wr_en;
    logic [1:0][4:0]       wr_addr;
    logic [1:0][31:0]      wr_data;
    logic [4:0]            rd_en;
    logic [4:0][4:0]       rd_addr;
    logic [4:0][31:0]      rd_data;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_main [32];
    logic [31:0] m_aux  [4];

    always #10 clk = ~clk;

    banked_regfile uut (.*);

    typedef struct packed {
        logic        port;
        logic        aux;
        logic [4:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'd0,  32'h1111_0000},
        '{1'b1, 1'b0, 5'd31, 32'hDEAD_BEEF},
        '{1'b0, 1'b0, 5'd17, 32'h0F0F_F0F0},
        '{1'b1, 1'b1, 5'd0,  32'hA5A5_0001},
        '{1'b0, 1'b1, 5'd3,  32'hA5A5_0003},
        '{1'b1, 1'b1, 5'd9,  32'hA5A5_0002},
        '{1'b0, 1'b1, 5'd26, 32'hA5A5_0004},
        '{1'b1, 1'b0, 5'd12, 32'h0000_0001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic stb, input logic inh, input logic aux, input logic [1:0] en,
                      input logic [4:0] a0, input logic [31:0] d0,
                      input logic [4:0] a1, input logic [31:0] d1);
        @(negedge clk);
        wr_strobe = stb; wr_inhibit = inh; wr_aux_sel = aux; wr_en = en;
        wr_addr[0] = a0; wr_data[0] = d0; wr_addr[1] = a1; wr_data[1] = d1;
        @(negedge clk);
        wr_strobe = 1'b0; wr_en = '0; wr_inhibit = 1'b0;
        if (stb && !inh) begin
            if (en[0]) begin if (aux) m_aux[a0[1:0]] = d0; else m_main[a0] = d0; end
            if (en[1]) begin if (aux) m_aux[a1[1:0]] = d1; else m_main[a1] = d1; end
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic en, input logic aux, input logic [4:0] a);
        if (!en) return '1;
        if (aux) return a[2] ? 32'hFFFF_FFFF : m_aux[a[1:0]];
        return m_main[a];
    endfunction

    task automatic rd(input logic [4:0] en, input logic aux, input logic [4:0][4:0] a, input string tag);
        @(negedge clk);
        rd_strobe = 1'b1; rd_aux_sel = aux; rd_en = en; rd_addr = a;
        @(negedge clk);
        rd_strobe = 1'b0;
        for (int p = 0; p < 5; p++)
            chk($sformatf("%s port%0d", tag, p), rd_data[p], expect_rd(en[p], aux, a[p]));
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [4:0][31:0] snap;
        rst = 1'b1; wr_strobe = 0; rd_strobe = 0; wr_inhibit = 0; wr_aux_sel = 0; rd_aux_sel = 0;
        wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
        for (int i = 0; i < 32; i++) m_main[i] = '0;
        for (int i = 0; i < 4; i++) m_aux[i] = '0;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 5; p++) chk("R1 reset output", rd_data[p], 32'hFFFF_FFFF);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 5; p++) chk("R1 post-reset output", rd_data[p], 32'hFFFF_FFFF);
        rd(5'b11111, 1'b0, {5'd31, 5'd20, 5'd9, 5'd1, 5'd0}, "R1 main zero");
        rd(5'b01111, 1'b1, {5'd0, 5'd3, 5'd2, 5'd1, 5'd0}, "R1 aux zero");

        // table walk: R2/R3 writes, R7/R8 reads on all ports
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].port)
                wr(1, 0, VECS[i].aux, 2'b10, 5'd0, 32'h0, VECS[i].addr, VECS[i].data);
            else
                wr(1, 0, VECS[i].aux, 2'b01, VECS[i].addr, VECS[i].data, 5'd0, 32'h0);
            rd(5'b11111, VECS[i].aux, {5{VECS[i].addr}}, VECS[i].aux ? "R3 R8 aux" : "R2 R7 main");
        end
        // R3: aux write with high address bits set leaves main entries 26 and 9 alone
        rd(5'b11111, 1'b0, {5'd26, 5'd9, 5'd26, 5'd9, 5'd31}, "R3 main untouched");

        // R6: dual-port write in one phase
        wr(1, 0, 0, 2'b11, 5'd5, 32'h5555_AAAA, 5'd6, 32'h6666_BBBB);
        rd(5'b11111, 1'b0, {5'd0, 5'd6, 5'd5, 5'd6, 5'd5}, "R6 dual write");

        // R4: inhibit
        wr(1, 1, 0, 2'b11, 5'd5, 32'h0BAD_0001, 5'd6, 32'h0BAD_0002);
        rd(5'b00011, 1'b0, {5'd0, 5'd0, 5'd0, 5'd6, 5'd5}, "R4 inhibit main");
        wr(1, 1, 1, 2'b01, 5'd1, 32'h0BAD_0003, 5'd0, 32'h0);
        rd(5'b00001, 1'b1, {5'd0, 5'd0, 5'd0, 5'd0, 5'd1}, "R4 inhibit aux");

        // R5: disabled port 1 writes nothing
        wr(1, 0, 0, 2'b01, 5'd7, 32'h7777_0000, 5'd8, 32'h0BAD_0008);
        rd(5'b00011, 1'b0, {5'd0, 5'd0, 5'd0, 5'd8, 5'd7}, "R5 port enable");

        // R12: no strobe, no write
        wr(0, 0, 0, 2'b11, 5'd7, 32'h0BAD_0007, 5'd8, 32'h0BAD_0009);
        rd(5'b00011, 1'b0, {5'd0, 5'd0, 5'd0, 5'd8, 5'd7}, "R12 no strobe");

        // R9: reserved bit set on aux read; mixed with valid aux reads
        rd(5'b11111, 1'b1, {5'd5, 5'd1, 5'd7, 5'd4, 5'd3}, "R9 R8 aux reserved");

        // R10: idle ports mixed with active ports
        rd(5'b10101, 1'b0, {5'd31, 5'd31, 5'd5, 5'd5, 5'd6}, "R10 idle port");

        // R11: hold with read strobe low while inputs move
        rd(5'b11111, 1'b0, {5'd31, 5'd17, 5'd12, 5'd6, 5'd5}, "R7 before hold");
        snap = rd_data;
        @(negedge clk);
        rd_en = 5'b00000; rd_aux_sel = 1'b1; rd_addr = {5{5'd4}};
        repeat (2) @(negedge clk);
        for (int p = 0; p < 5; p++) chk($sformatf("R11 hold port%0d", p), rd_data[p], snap[p]);

        // R11: a write phase also leaves outputs alone
        wr(1, 0, 0, 2'b01, 5'd31, 32'h3131_3131, 5'd0, 32'h0);
        for (int p = 0; p < 5; p++) chk($sformatf("R11 hold over write port%0d", p), rd_data[p], snap[p]);
        rd(5'b00001, 1'b0, {5'd0, 5'd0, 5'd0, 5'd0, 5'd31}, "R2 overwrite");

        // R1: reset mid-run clears storage
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 32; i++) m_main[i] = '0;
        for (int i = 0; i < 4; i++) m_aux[i] = '0;
        for (int p = 0; p < 5; p++) chk("R1 re-reset output", rd_data[p], 32'hFFFF_FFFF);
        rd(5'b11111, 1'b0, {5'd5, 5'd6, 5'd17, 5'd31, 5'd0}, "R1 main cleared");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule